// File: doc/BRIEF.md
# Iterative AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block with a 128-bit key, working through one round per clock. A key is first handed over with a load strobe. The engine then expands that key into eleven 128-bit round keys, one per clock, and keeps them in internal storage. After that, any number of blocks can be processed under the same key. The mode bit is sampled together with the start strobe. The same round datapath serves both directions. For decryption it applies the inverse steps and walks the stored round keys from the last one back to the first.

Bytes map to the 4x4 state column by column. Bits [127:120] of a bus are byte 0, which is row 0 of column 0. Bits [119:112] are byte 1, which is row 1 of column 0, and so on up to bits [7:0], which are row 3 of column 3. The same mapping applies to the key, the input block and the output block. One whitening step and ten rounds take eleven clocks. The result then sits on the output until a later operation completes.

Top module: `aes_core`

## Requirements
- R1: While reset is high, and in the first cycle after it, `data_out` is all zeros and both `done` and `busy` are low.
- R2: A `key_load` accepted while idle raises `busy` from the next clock edge for exactly 10 cycles, while the round keys are computed. `busy` is low after the 10th edge.
- R3: With `mode` = 0 (encrypt), the block on `data_in` is whitened with round key 0. Rounds 1 to 10 then each apply byte substitution, row shift, column mix (skipped in round 10) and the XOR of that round's key. The result matches the standard AES-128 ciphertext.
- R4: With `mode` = 1 (decrypt), the block is whitened with round key 10. Each following round applies inverse row shift, inverse substitution, the XOR of round key 10-r, and inverse column mix (skipped in the last round). The result is the original plaintext.
- R5: `done` is high for exactly one cycle. It rises after the 11th clock edge following the edge that accepts `start`.
- R6: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high.
- R7: A `start` is ignored while `busy` is high, whether a key is being expanded or a block is being processed. A `start` that coincides with an accepted `key_load` is also ignored.
- R8: A `key_load` is ignored while `busy` is high. The round keys in use stay unchanged.
- R9: `data_out` changes only on the edge that raises `done`, and holds its value in every other cycle.
- R10: `mode` and `data_in` are sampled only on the edge that accepts `start`. Changing them later has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 128 | Cipher key, byte 0 in bits [127:120] |
| key_load | input | 1 | Strobe: expand `key_in` into the round keys |
| data_in | input | 128 | Block to process, byte 0 in bits [127:120] |
| mode | input | 1 | 0 = encrypt, 1 = decrypt; sampled with `start` |
| start | input | 1 | Strobe: begin processing `data_in` |
| data_out | output | 128 | Result block, held between operations |
| done | output | 1 | One-cycle pulse when `data_out` is updated |
| busy | output | 1 | High during key expansion or block processing |

## Verification
A result is due 11 edges after the edge that accepts `start`, and `busy` falls 10 edges after an accepted key load. The bench drives every input on the falling edge and samples once per falling edge. It counts edges exactly, so `done` must be low in each of the 11 samples before it is due and high in the one where it is due. `busy` is checked in every one of those samples. Disturbances are injected at fixed counts inside these windows: a second start, a key load, or a flipped mode and data. The result must still appear on schedule and must equal the undisturbed value.

// File: rtl/aes_pkg.sv
package aes_pkg;

    localparam int BLK_W   = 128;
    localparam int WORD_W  = 32;
    localparam int NROUND  = 10;
    localparam int NBYTE   = BLK_W / 8;
    localparam int NCOL    = BLK_W / WORD_W;
    localparam int STEP_W  = $clog2(NROUND + 1);

    typedef logic [BLK_W-1:0]  block_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [7:0]        byte_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WHITEN = 2'd1,
        ST_ROUND  = 2'd2
    } run_st_e;

    typedef struct packed {
        run_st_e           st;
        logic [STEP_W-1:0] step;
        logic              dec;
    } run_ctl_t;

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t p;
        byte_t aa;
        p  = '0;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = xtime(aa);
        end
        return p;
    endfunction

    function automatic byte_t rotl8(input byte_t b, input int n);
        return byte_t'((b << n) | (b >> (8 - n)));
    endfunction

    // multiplicative inverse as x^254; zero maps to zero
    function automatic byte_t gf_inv(input byte_t x);
        byte_t pw;
        byte_t acc;
        pw  = x;
        acc = 8'h01;
        for (int i = 0; i < 7; i++) begin
            pw  = gmul(pw, pw);
            acc = gmul(acc, pw);
        end
        return acc;
    endfunction

    function automatic byte_t sbox(input byte_t x);
        byte_t v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic byte_t inv_sbox(input byte_t x);
        return gf_inv(rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05);
    endfunction

    // byte n sits in row n%4, column n/4
    function automatic block_t shift_rows(input block_t s);
        block_t o;
        for (int n = 0; n < NBYTE; n++) begin
            int r;
            int c;
            int src;
            r   = n % 4;
            c   = n / 4;
            src = ((c + r) % 4) * 4 + r;
            o[BLK_W-1-8*n -: 8] = s[BLK_W-1-8*src -: 8];
        end
        return o;
    endfunction

    function automatic block_t inv_shift_rows(input block_t s);
        block_t o;
        for (int n = 0; n < NBYTE; n++) begin
            int r;
            int c;
            int src;
            r   = n % 4;
            c   = n / 4;
            src = ((c + 4 - r) % 4) * 4 + r;
            o[BLK_W-1-8*n -: 8] = s[BLK_W-1-8*src -: 8];
        end
        return o;
    endfunction

    function automatic word_t mix_col(input word_t w);
        byte_t a0, a1, a2, a3;
        {a0, a1, a2, a3} = w;
        return {gmul(a0, 8'h02) ^ gmul(a1, 8'h03) ^ a2 ^ a3,
                a0 ^ gmul(a1, 8'h02) ^ gmul(a2, 8'h03) ^ a3,
                a0 ^ a1 ^ gmul(a2, 8'h02) ^ gmul(a3, 8'h03),
                gmul(a0, 8'h03) ^ a1 ^ a2 ^ gmul(a3, 8'h02)};
    endfunction

    function automatic word_t inv_mix_col(input word_t w);
        byte_t a0, a1, a2, a3;
        {a0, a1, a2, a3} = w;
        return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
                gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
                gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
                gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
    endfunction

    // one group of four schedule words from the previous group
    function automatic block_t expand_key(input block_t prev, input byte_t rcon);
        word_t w0, w1, w2, w3, t, n0, n1, n2, n3;
        {w0, w1, w2, w3} = prev;
        t  = {sbox(w3[23:16]) ^ rcon, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
        n0 = w0 ^ t;
        n1 = w1 ^ n0;
        n2 = w2 ^ n1;
        n3 = w3 ^ n2;
        return {n0, n1, n2, n3};
    endfunction

endpackage

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import aes_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  block_t            key_i,
    input  logic [STEP_W-1:0] rd_idx_i,
    output block_t            rd_key_o,
    output logic              busy_o
);
    localparam logic [STEP_W-1:0] LAST_GRP = STEP_W'(NROUND);

    block_t            rk_q [NROUND+1];
    block_t            prev_q;
    block_t            grp_next;
    logic [STEP_W-1:0] cnt_q;
    byte_t             rcon_q;
    logic              act_q;

    assign grp_next = expand_key(prev_q, rcon_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= NROUND; i++) rk_q[i] <= '0;
            prev_q <= '0;
            cnt_q  <= '0;
            rcon_q <= 8'h01;
            act_q  <= 1'b0;
        end else if (load_i) begin
            rk_q[0] <= key_i;
            prev_q  <= key_i;
            cnt_q   <= STEP_W'(1);
            rcon_q  <= 8'h01;
            act_q   <= 1'b1;
        end else if (act_q) begin
            rk_q[cnt_q] <= grp_next;
            prev_q      <= grp_next;
            rcon_q      <= xtime(rcon_q);
            cnt_q       <= cnt_q + STEP_W'(1);
            if (cnt_q == LAST_GRP) act_q <= 1'b0;
        end
    end

    assign rd_key_o = rk_q[rd_idx_i];
    assign busy_o   = act_q;

endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_pkg::*;
(
    input  block_t state_i,
    input  block_t rkey_i,
    input  logic   inv_i,
    input  logic   last_i,
    output block_t state_o
);
    block_t enc_sub, enc_sh, enc_mix, enc_out;
    block_t dec_sh, dec_sub, dec_ak, dec_mix, dec_out;

    assign dec_sh = inv_shift_rows(state_i);

    for (genvar b = 0; b < NBYTE; b++) begin : g_sub
        assign enc_sub[BLK_W-1-8*b -: 8] = sbox(state_i[BLK_W-1-8*b -: 8]);
        assign dec_sub[BLK_W-1-8*b -: 8] = inv_sbox(dec_sh[BLK_W-1-8*b -: 8]);
    end

    assign enc_sh = shift_rows(enc_sub);
    assign dec_ak = dec_sub ^ rkey_i;

    for (genvar c = 0; c < NCOL; c++) begin : g_mix
        assign enc_mix[BLK_W-1-WORD_W*c -: WORD_W] = mix_col(enc_sh[BLK_W-1-WORD_W*c -: WORD_W]);
        assign dec_mix[BLK_W-1-WORD_W*c -: WORD_W] = inv_mix_col(dec_ak[BLK_W-1-WORD_W*c -: WORD_W]);
    end

    assign enc_out = (last_i ? enc_sh : enc_mix) ^ rkey_i;
    assign dec_out = last_i ? dec_ak : dec_mix;
    assign state_o = inv_i ? dec_out : enc_out;

endmodule

// File: rtl/aes_core.sv
module aes_core
    import aes_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [127:0] key_in,
    input  logic         key_load,
    input  logic [127:0] data_in,
    input  logic         mode,
    input  logic         start,
    output logic [127:0] data_out,
    output logic         done,
    output logic         busy
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NROUND);

    run_ctl_t          ctl_q;
    block_t            blk_q;
    block_t            out_q;
    block_t            rkey;
    block_t            rnd_out;
    logic              done_q;
    logic              ks_busy;
    logic              take_key;
    logic              take_go;
    logic [STEP_W-1:0] cur_step;
    logic [STEP_W-1:0] key_idx;

    assign busy     = ks_busy | (ctl_q.st != ST_IDLE);
    assign take_key = key_load & ~busy;
    assign take_go  = start & ~busy & ~key_load;

    assign cur_step = (ctl_q.st == ST_ROUND) ? ctl_q.step : '0;
    assign key_idx  = ctl_q.dec ? (LAST_STEP - cur_step) : cur_step;

    aes_key_sched u_ks (
        .clk      (clk),
        .rst      (rst),
        .load_i   (take_key),
        .key_i    (key_in),
        .rd_idx_i (key_idx),
        .rd_key_o (rkey),
        .busy_o   (ks_busy)
    );

    aes_round u_round (
        .state_i (blk_q),
        .rkey_i  (rkey),
        .inv_i   (ctl_q.dec),
        .last_i  (ctl_q.step == LAST_STEP),
        .state_o (rnd_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{st: ST_IDLE, step: '0, dec: 1'b0};
            blk_q  <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (take_go) begin
                        blk_q     <= data_in;
                        ctl_q.dec <= mode;
                        ctl_q.st  <= ST_WHITEN;
                    end
                end
                ST_WHITEN: begin
                    blk_q      <= blk_q ^ rkey;
                    ctl_q.step <= STEP_W'(1);
                    ctl_q.st   <= ST_ROUND;
                end
                ST_ROUND: begin
                    if (ctl_q.step == LAST_STEP) begin
                        out_q      <= rnd_out;
                        done_q     <= 1'b1;
                        ctl_q.st   <= ST_IDLE;
                        ctl_q.step <= '0;
                    end else begin
                        blk_q      <= rnd_out;
                        ctl_q.step <= ctl_q.step + STEP_W'(1);
                    end
                end
                default: ctl_q.st <= ST_IDLE;
            endcase
        end
    end

    assign data_out = out_q;
    assign done     = done_q;

endmodule

// File: rtl/aes_core_chk.sv
module aes_core_chk (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic         busy,
    input logic [127:0] data_out
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && !busy && data_out == '0));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r9_out_holds: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(data_out));
endmodule

bind aes_core aes_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .busy     (busy),
    .data_out (data_out)
);

// File: tb/aes_core_bench.sv
module aes_core_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] key_in = '0;
    logic         key_load = 1'b0;
    logic [127:0] data_in = '0;
    logic         mode = 1'b0;
    logic         start = 1'b0;
    logic [127:0] data_out;
    logic         done;
    logic         busy;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    aes_core u_aes_core (
        .clk(clk), .rst(rst), .key_in(key_in), .key_load(key_load),
        .data_in(data_in), .mode(mode), .start(start),
        .data_out(data_out), .done(done), .busy(busy)
    );

    // {key, plaintext, ciphertext}
    localparam logic [383:0] VEC [0:2] = '{
        {128'h000102030405060708090a0b0c0d0e0f,
         128'h00112233445566778899aabbccddeeff,
         128'h69c4e0d86a7b0430d8cdb78070b4c55a},
        {128'h2b7e151628aed2a6abf7158809cf4f3c,
         128'h3243f6a8885a308d313198a2e0370734,
         128'h3925841d02dc09fbdc118597196a0b32},
        {128'h00000000000000000000000000000000,
         128'h00000000000000000000000000000000,
         128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R2: busy for exactly 10 cycles after an accepted key load
    task automatic load_key(input logic [127:0] k);
        bit ok;
        ok = 1'b1;
        key_in   = k;
        key_load = 1'b1;
        cyc();
        key_load = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (!busy) ok = 1'b0;
            cyc();
        end
        if (busy) ok = 1'b0;
        chk(ok, "R2 key busy window", {127'b0, busy}, 128'd0);
    endtask

    // disturb: 0 none, 1 second start (R7), 2 key load (R8), 3 mode/data change (R10)
    task automatic run(input logic m, input logic [127:0] din, input int disturb,
                       output logic [127:0] res);
        bit ok;
        ok      = 1'b1;
        mode    = m;
        data_in = din;
        start   = 1'b1;
        cyc();
        start = 1'b0;
        for (int i = 0; i <= 10; i++) begin
            if (done || !busy) ok = 1'b0;
            if (i == 3) begin
                if (disturb == 1) begin
                    start = 1'b1; data_in = ~din; mode = ~m;
                end
                if (disturb == 2) begin
                    key_load = 1'b1; key_in = ~key_in;
                end
                if (disturb == 3) begin
                    mode = ~m; data_in = ~din;
                end
            end
            if (i == 4) begin
                start = 1'b0; key_load = 1'b0;
                if (disturb != 3) begin
                    mode = m; data_in = din;
                end
            end
            cyc();
        end
        if (!done || busy) ok = 1'b0;
        res = data_out;
        cyc();
        if (done) ok = 1'b0;
        mode = m; data_in = din;
        chk(ok, "R5,R6 done/busy timing", {126'b0, done, busy}, 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] r;
        logic [127:0] held;
        bit ok;
        repeat (3) cyc();
        // R1: reset state
        chk(data_out == '0 && !done && !busy, "R1 reset state", data_out, 128'd0);
        rst = 1'b0;
        cyc();
        chk(data_out == '0 && !done && !busy, "R1 after reset", data_out, 128'd0);

        for (int v = 0; v < 3; v++) begin
            load_key(VEC[v][383:256]);
            run(1'b0, VEC[v][255:128], 0, r);
            chk(r == VEC[v][127:0], "R3 encrypt", r, VEC[v][127:0]);
            run(1'b1, VEC[v][127:0], 0, r);
            chk(r == VEC[v][255:128], "R4 decrypt", r, VEC[v][255:128]);
        end

        // R9: output holds after done
        held = data_out;
        ok = 1'b1;
        repeat (6) begin
            cyc();
            if (data_out != held || done) ok = 1'b0;
        end
        chk(ok, "R9 output hold", data_out, held);

        // R7: start during key expansion is ignored
        load_key(VEC[0][383:256]);
        key_in = VEC[1][383:256]; key_load = 1'b1;
        cyc();
        key_load = 1'b0;
        held = data_out;
        ok = 1'b1;
        start = 1'b1; data_in = VEC[0][255:128]; mode = 1'b0;
        cyc();
        start = 1'b0;
        repeat (14) begin
            if (done || data_out != held) ok = 1'b0;
            cyc();
        end
        chk(ok, "R7 start during key expansion", data_out, held);
        // schedule now holds key of vector 1
        run(1'b0, VEC[1][255:128], 0, r);
        chk(r == VEC[1][127:0], "R3 after key reload", r, VEC[1][127:0]);

        // R7: second start during processing
        run(1'b0, VEC[1][255:128], 1, r);
        chk(r == VEC[1][127:0], "R7 start while running", r, VEC[1][127:0]);
        cyc();
        chk(!done && !busy, "R7 no extra operation", {126'b0, done, busy}, 128'd0);

        // R8: key load during processing is ignored
        key_in = VEC[1][383:256];
        run(1'b1, VEC[1][127:0], 2, r);
        chk(r == VEC[1][255:128], "R8 key load while running", r, VEC[1][255:128]);
        chk(!busy, "R8 no expansion started", {127'b0, busy}, 128'd0);
        run(1'b0, VEC[1][255:128], 0, r);
        chk(r == VEC[1][127:0], "R8 schedule intact", r, VEC[1][127:0]);

        // R10: mode and data changed mid-run
        run(1'b0, VEC[1][255:128], 3, r);
        chk(r == VEC[1][127:0], "R10 inputs sampled at start", r, VEC[1][127:0]);
        run(1'b1, VEC[1][127:0], 3, r);
        chk(r == VEC[1][255:128], "R10 decrypt inputs sampled at start", r, VEC[1][255:128]);

        // R7: start coinciding with key load is ignored
        held = data_out;
        key_in = VEC[0][383:256]; key_load = 1'b1; start = 1'b1;
        cyc();
        key_load = 1'b0; start = 1'b0;
        ok = 1'b1;
        repeat (14) begin
            if (done || data_out != held) ok = 1'b0;
            cyc();
        end
        chk(ok, "R7 start with key load", data_out, held);
        run(1'b0, VEC[0][255:128], 0, r);
        chk(r == VEC[0][127:0], "R3 key from simultaneous load", r, VEC[0][127:0]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule